// File: doc/BRIEF.md
# Multi-channel prescaled interval timer

A bank of six independent down-counters that software sets up through a small word-addressed register port. Each channel holds a 32-bit interval and a 32-bit live count, and has a control word. The control word selects one of three incoming tick strobes, a power-of-two prescale and a repeat mode. The channel counts down once for every prescaled tick. When the count reaches zero it raises a pending flag in a shared status register. A shared enable register masks each pending flag onto a single interrupt line.

The tick strobes are one-cycle pulses in the `clk` domain. They stand in for the slow oscillator, the main oscillator and an alternate source. Clock generation is outside this block. Software loads the interval, then writes the control word with the reload bit set so that the counter is primed. It then either lets the channel run continuously or uses it as a one-shot.

Top module: `prescaled_interval_timer`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: Word addresses: 0 is the interrupt-enable register and 1 is the pending-status register. Bit c of each belongs to channel c. Channel c uses base address 4*(c+1): base+0 is control, base+1 is interval, base+2 is current count. The current count is read-only, so a write to it leaves the value unchanged. Other addresses read zero.
- R3: Control bit 1 is the reload bit. On the first clock edge after it is written as 1, the interval is copied into the current count. The bit still reads 1 until the next edge, when it clears itself. The prescaler restarts during a reload, and no count occurs while the bit is set.
- R4: Control bit 0 enables the channel. A disabled channel ignores all ticks, and its current count is held.
- R5: Control bits 3:2 select the tick input: 0 is `tick_slow`, 1 is `tick_main`, 2 is `tick_alt` and 3 is no input. Ticks on the inputs that are not selected have no effect.
- R6: Control bits 6:4 hold a code k. The channel counts once per 2^k selected ticks, from /1 for code 0 to /128 for code 7. The prescaler restarts from zero while the channel is disabled.
- R7: Each counting step decrements the current count. The step that takes the count from 1 to 0 sets the channel's pending bit.
- R8: With control bit 7 at 0 (continuous), a counting step taken at a count of zero reloads the interval. The period is therefore interval+1 steps.
- R9: With control bit 7 at 1 (one-shot), reaching zero clears the enable bit. The count then stays at zero.
- R10: A pending bit is set whether or not its interrupt enable is set. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A set on the same edge as a clear wins.
- R11: `irq_o` is high exactly when some channel has both its pending bit and its enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_slow | input | 1 | Slow-oscillator tick strobe |
| tick_main | input | 1 | Main-oscillator tick strobe |
| tick_alt | input | 1 | Alternate-source tick strobe |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A wrong prescaler phase or source selection appears on the current-count read as an early or late decrement. It is visible on the first count that should have moved. A faulty zero-crossing shows up one edge after the 1-to-0 step, either as a missing or spurious pending bit in the status word or as a count that does not wrap back to the interval. A reload path stuck in the wrong state shows within two edges of the control write, through the reload bit that reads back in the control word.

// File: rtl/prescaled_interval_timer.sv
module prescaled_interval_timer #(
  parameter int NCH = 6,
  parameter int DW = 32,
  parameter int PSC_BITS = 3,
  localparam int AW = $clog2(4 * (NCH + 1)),
  localparam int PW = (1 << PSC_BITS) - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_slow,
  input  logic          tick_main,
  input  logic          tick_alt,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_o
);

  logic [NCH-1:0] en_q, rld_q, rld_done_q, mode_q;
  logic [NCH-1:0] irq_en_q, irq_sta_q;
  logic [NCH-1:0] hit, wr_ctrl;
  logic [1:0]     src_q  [NCH];
  logic [PSC_BITS-1:0] psc_q [NCH];
  logic [PW-1:0]  pcnt_q [NCH];
  logic [DW-1:0]  ivl_q  [NCH];
  logic [DW-1:0]  cur_q  [NCH];

  wire wr_ien = reg_wr && reg_addr == AW'(0);
  wire wr_sta = reg_wr && reg_addr == AW'(1);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [AW-1:0] BASE = AW'(4 * (c + 1));
    logic src_tick, fire, count;
    logic [PW-1:0] mask;

    assign wr_ctrl[c] = reg_wr && reg_addr == BASE;
    wire   wr_ivl     = reg_wr && reg_addr == BASE + AW'(1);

    always_comb begin
      case (src_q[c])
        2'd0:    src_tick = tick_slow;
        2'd1:    src_tick = tick_main;
        2'd2:    src_tick = tick_alt;
        default: src_tick = 1'b0;
      endcase
    end

    assign mask  = ~({PW{1'b1}} << psc_q[c]);
    assign fire  = en_q[c] && src_tick && ((pcnt_q[c] & mask) == mask);
    assign count = fire && !rld_q[c] && !wr_ctrl[c];
    assign hit[c] = count && cur_q[c] == DW'(1);

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[c] <= 1'b0; rld_q[c] <= 1'b0; rld_done_q[c] <= 1'b0; mode_q[c] <= 1'b0;
        src_q[c] <= '0; psc_q[c] <= '0; pcnt_q[c] <= '0;
        ivl_q[c] <= '0; cur_q[c] <= '0;
      end else begin
        if (!en_q[c] || rld_q[c]) pcnt_q[c] <= '0;
        else if (src_tick)        pcnt_q[c] <= pcnt_q[c] + PW'(1);

        if (wr_ivl) ivl_q[c] <= reg_wdata;

        if (wr_ctrl[c]) begin
          en_q[c]       <= reg_wdata[0];
          rld_q[c]      <= reg_wdata[1];
          src_q[c]      <= reg_wdata[3:2];
          psc_q[c]      <= reg_wdata[4 +: PSC_BITS];
          mode_q[c]     <= reg_wdata[7];
          rld_done_q[c] <= 1'b0;
        end else if (rld_q[c]) begin
          if (!rld_done_q[c]) begin
            cur_q[c]      <= ivl_q[c];
            rld_done_q[c] <= 1'b1;
          end else begin
            rld_q[c]      <= 1'b0;
            rld_done_q[c] <= 1'b0;
          end
        end else if (count) begin
          if (cur_q[c] == '0) begin
            if (!mode_q[c]) cur_q[c] <= ivl_q[c];
            else            en_q[c]  <= 1'b0;
          end else begin
            cur_q[c] <= cur_q[c] - DW'(1);
            if (cur_q[c] == DW'(1) && mode_q[c]) en_q[c] <= 1'b0;
          end
        end
      end
    end

    a_r7_zero_sets_pending: assert property (@(posedge clk) disable iff (rst)
      hit[c] |=> irq_sta_q[c]);
    a_r7_pending_rises_at_zero: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_sta_q[c]) |-> cur_q[c] == '0);
    a_r9_oneshot_stops: assert property (@(posedge clk) disable iff (rst)
      (hit[c] && mode_q[c]) |=> !en_q[c]);
    a_r3_reload_self_clears: assert property (@(posedge clk) disable iff (rst)
      (rld_q[c] && rld_done_q[c] && !wr_ctrl[c]) |=> !rld_q[c]);
    a_r3_reload_copies: assert property (@(posedge clk) disable iff (rst)
      (rld_q[c] && !rld_done_q[c] && !wr_ctrl[c]) |=> cur_q[c] == $past(ivl_q[c]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en_q  <= '0;
      irq_sta_q <= '0;
    end else begin
      if (wr_ien) irq_en_q <= reg_wdata[NCH-1:0];
      irq_sta_q <= (irq_sta_q & ~(wr_sta ? reg_wdata[NCH-1:0] : '0)) | hit;
    end
  end

  assign irq_o = |(irq_sta_q & irq_en_q);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(0)) reg_rdata = DW'(irq_en_q);
    else if (reg_addr == AW'(1)) reg_rdata = DW'(irq_sta_q);
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == AW'(4 * (c + 1)))
        reg_rdata = DW'({mode_q[c], psc_q[c], src_q[c], rld_q[c], en_q[c]});
      else if (reg_addr == AW'(4 * (c + 1) + 1)) reg_rdata = ivl_q[c];
      else if (reg_addr == AW'(4 * (c + 1) + 2)) reg_rdata = cur_q[c];
    end
  end

  a_r11_irq_has_pending: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> irq_sta_q != '0);
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> !irq_o && irq_sta_q == '0);

endmodule

// File: tb/tb_prescaled_interval_timer.sv
module tb_prescaled_interval_timer;
  localparam int PERIOD = 10;

  logic clk = 0, rst = 1;
  logic tick_slow = 0, tick_main = 0, tick_alt = 0;
  logic reg_wr = 0;
  logic [4:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic irq_o;

  prescaled_interval_timer dut (
    .clk(clk), .rst(rst), .tick_slow(tick_slow), .tick_main(tick_main),
    .tick_alt(tick_alt), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  initial begin
    forever begin
      @(negedge clk);
      #(PERIOD/4);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = it.is_irq ? {31'b0, irq_o} : reg_rdata;
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic chk(input logic [4:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    reg_addr = a;
    it.is_irq = 0; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic chk_irq(input bit e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1; it.exp = {31'b0, e}; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic tk(input int src, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_slow = (src == 0); tick_main = (src == 1); tick_alt = (src == 2);
    end
    @(negedge clk);
    tick_slow = 0; tick_main = 0; tick_alt = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(5'd4, 32'h0, "R1 ctrl0");
    chk(5'd1, 32'h0, "R1 status");
    chk(5'd6, 32'h0, "R1 cur0");
    chk_irq(0, "R1 irq");

    // channel 0: interval 3, enable, reload, main source, /1, continuous
    wr(5'd5, 32'd3);
    wr(5'd4, 32'h07);
    chk(5'd4, 32'h07, "R3 reload bit still set");
    chk(5'd4, 32'h05, "R3 reload bit self-cleared");
    chk(5'd6, 32'd3, "R3 interval copied");

    tk(1, 2);
    chk(5'd6, 32'd1, "R7 decrement per tick");
    tk(1, 1);
    chk(5'd6, 32'd0, "R7 reached zero");
    chk(5'd1, 32'h1, "R10 pending without enable");
    chk_irq(0, "R11 masked");

    tk(0, 2);
    chk(5'd6, 32'd0, "R5 unselected source ignored");
    tk(1, 1);
    chk(5'd6, 32'd3, "R8 continuous reload at zero");

    wr(5'd0, 32'h1);
    chk_irq(1, "R11 enabled pending");
    wr(5'd1, 32'h2);
    chk(5'd1, 32'h1, "R10 write 0 keeps bit");
    wr(5'd1, 32'h1);
    chk(5'd1, 32'h0, "R10 write 1 clears");
    chk_irq(0, "R11 cleared");

    wr(5'd6, 32'h55);
    chk(5'd6, 32'd3, "R2 current count read-only");
    chk(5'd3, 32'h0, "R2 unmapped reads zero");

    // channel 2: interval 10, alt source, /4, one-shot
    wr(5'd13, 32'd10);
    wr(5'd12, 32'hAB);
    chk(5'd14, 32'd10, "R3 ch2 copied");
    chk(5'd12, 32'hA9, "R3 ch2 reload cleared");
    tk(2, 3);
    chk(5'd14, 32'd10, "R6 /4 no count after 3 ticks");
    tk(2, 1);
    chk(5'd14, 32'd9, "R6 /4 count on 4th tick");
    tk(2, 36);
    chk(5'd14, 32'd0, "R9 one-shot reached zero");
    chk(5'd12, 32'hA8, "R9 enable cleared");
    chk(5'd1, 32'h4, "R7 ch2 pending");
    tk(2, 8);
    chk(5'd14, 32'd0, "R9 stays at zero");
    chk_irq(0, "R11 ch2 masked");
    wr(5'd0, 32'h5);
    chk_irq(1, "R11 ch2 enabled");

    // channel 5: interval 1, slow source, /128, continuous
    wr(5'd25, 32'd1);
    wr(5'd24, 32'h73);
    chk(5'd24, 32'h73, "R3 ch5 reload set");
    chk(5'd26, 32'd1, "R3 ch5 copied");
    tk(0, 127);
    chk(5'd26, 32'd1, "R6 /128 holds before 128th tick");
    tk(0, 1);
    chk(5'd26, 32'd0, "R6 /128 counts on 128th tick");
    chk(5'd1, 32'h24, "R7 ch5 pending");

    // channel 1: reload while disabled, then ticks ignored
    wr(5'd9, 32'd5);
    wr(5'd8, 32'h06);
    chk(5'd10, 32'd5, "R3 reload while disabled");
    tk(1, 3);
    chk(5'd10, 32'd5, "R4 disabled ignores ticks");

    repeat (3) @(negedge clk);
    wait (q.size() == 0);
    done = 1;
    finish_run();
  end
endmodule